// File: doc/BRIEF.md
# Split-Phase Full-Duplex SPI Master

This block is a serial peripheral master that moves one byte out on its data output and one byte in from its data input during each transfer. It has three configuration inputs: the clock idle level, the transmit phase and the receive phase. The transmit phase sets the edges on which outgoing data moves. The receive phase sets the edges on which incoming data is captured. Because the two phases are separate inputs, all four launch/capture pairings are valid. A controller can therefore talk to a slave whose output timing does not mirror its input timing.

Software writes a byte, selects the mode and the rate divider, and raises a start strobe for one cycle. The block raises busy, produces sixteen serial clock edges with a half-period of (divider + 1) system cycles, and ends with the clock back at its idle level. It then updates the received byte and raises done for one cycle. The configuration and the divider are captured when a transfer starts. Chip select is driven from a general-purpose output elsewhere, around the transfer.

Top module: `spi_split_master`

## Requirements
- R1: While reset is active and just after it, busy_o, done_o, mosi_o and rx_byte_o are all 0.
- R2: While no transfer is running, sclk_o equals cpol_i (0 = idle low, 1 = idle high). After the last edge of a transfer, sclk_o is back at the captured idle level.
- R3: With tx_phase_i = 0, mosi_o carries the most significant bit from the cycle after start is accepted, before any clock edge. Bits follow MSB first, and each is valid on edges 1, 3, ..., 15 (the slave capture edges).
- R4: With tx_phase_i = 1, mosi_o keeps its previous value until the first clock edge. Bits follow MSB first, and each is valid on edges 2, 4, ..., 16 (the slave capture edges).
- R5: With rx_phase_i = 0, miso_i is captured on edges 1, 3, ..., 15, MSB first.
- R6: With rx_phase_i = 1, miso_i is captured on edges 2, 4, ..., 16, MSB first.
- R7: mosi_o never changes on an edge where the slave captures data.
- R8: A transfer has exactly 16 serial clock edges, and consecutive edges are (div_i + 1) system cycles apart.
- R9: Counting the cycle that accepts start as cycle 0, done_o is high for exactly one cycle, seen in cycle 16*(div_i+1). busy_o falls in that same cycle.
- R10: A start strobe while busy_o is high has no effect: the running transfer's timing, data and mode are unchanged.
- R11: rx_byte_o changes only when done_o is raised, and holds its value until the next transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| tx_byte_i | input | DATA_W | Byte to send |
| cpol_i | input | 1 | Serial clock idle level |
| tx_phase_i | input | 1 | Transmit phase select |
| rx_phase_i | input | 1 | Receive phase select |
| div_i | input | DIV_W | Half-period minus one, in system cycles |
| rx_byte_o | output | DATA_W | Last received byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and DIV_W = 8. This gives 16 edges per transfer and a divider range up to 255. Divider values 0, 1, 3 and 255 are used. Value 0 places edges on back-to-back system cycles, so the launch and capture logic is stressed with no slack. Value 255 exercises the full divider width. All four phase pairings run under both clock polarities.

// File: rtl/spi_split_pkg.sv
package spi_split_pkg;
  typedef struct packed {
    logic cpol;
    logic tx_ph;
    logic rx_ph;
  } spi_cfg_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_W  = 8,
  parameter int EDGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cpol_i,
  output logic              tick_o,
  output logic [EDGE_W-1:0] edge_idx_o,
  output logic              sclk_o
);
  logic [DIV_W-1:0]  div_q, cnt_q;
  logic [EDGE_W-1:0] edge_q;
  logic              sclk_q;

  assign tick_o     = run_i && (cnt_q == div_q);
  assign edge_idx_o = edge_q;
  assign sclk_o     = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      cnt_q  <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
    end else if (load_i) begin
      div_q  <= div_i;
      cnt_q  <= '0;
      edge_q <= '0;
      sclk_q <= cpol_i;
    end else if (run_i) begin
      if (cnt_q == div_q) begin
        cnt_q  <= '0;
        edge_q <= edge_q + 1'b1;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // clock toggles only when the half-period counter has expired
  assert_half_period_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sclk_q) && !$past(load_i)) |-> $past(cnt_q == div_q));
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8,
  parameter int EDGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_ph_i,
  input  logic              rx_ph_i,
  input  logic              tick_i,
  input  logic [EDGE_W-1:0] edge_idx_i,
  input  logic              last_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic              mosi_q;
  logic              odd_edge, launch, sample, slave_cap;

  // edge number is edge_idx + 1
  assign odd_edge  = ~edge_idx_i[0];
  assign launch    = tick_i && (tx_ph_i ? odd_edge : ~odd_edge) && !last_i;
  assign sample    = tick_i && (rx_ph_i ? ~odd_edge : odd_edge);
  assign slave_cap = tick_i && (tx_ph_i ? ~odd_edge : odd_edge);
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr  <= '0;
      mosi_q <= 1'b0;
    end else if (load_i) begin
      if (tx_ph_i) begin
        tx_sr <= tx_byte_i;
      end else begin
        tx_sr  <= tx_byte_i << 1;
        mosi_q <= tx_byte_i[DATA_W-1];
      end
    end else if (launch) begin
      mosi_q <= tx_sr[DATA_W-1];
      tx_sr  <= tx_sr << 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr     <= '0;
      rx_byte_o <= '0;
    end else begin
      if (sample) rx_sr <= {rx_sr[DATA_W-2:0], miso_i};
      if (tick_i && last_i)
        rx_byte_o <= rx_ph_i ? {rx_sr[DATA_W-2:0], miso_i} : rx_sr;
    end
  end

  assert_mosi_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_cap |=> $stable(mosi_q));
  assert_rx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && last_i) |=> $stable(rx_byte_o));
endmodule

// File: rtl/spi_split_master.sv
module spi_split_master
  import spi_split_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              cpol_i,
  input  logic              tx_phase_i,
  input  logic              rx_phase_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  spi_cfg_t          cfg_in, cfg_q, cfg_eff;
  logic              busy_q, done_q, load, tick, last, sclk_raw;
  logic [EDGE_W-1:0] edge_idx;

  assign cfg_in  = '{cpol: cpol_i, tx_ph: tx_phase_i, rx_ph: rx_phase_i};
  assign load    = start_i && !busy_q;
  assign cfg_eff = load ? cfg_in : cfg_q;
  assign last    = (edge_idx == EDGE_W'(EDGES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= tick && last;
      if (load) begin
        cfg_q  <= cfg_in;
        busy_q <= 1'b1;
      end else if (tick && last) begin
        busy_q <= 1'b0;
      end
    end
  end

  spi_rate_gen #(.DIV_W(DIV_W), .EDGE_W(EDGE_W)) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .run_i      (busy_q),
    .div_i      (div_i),
    .cpol_i     (cfg_in.cpol),
    .tick_o     (tick),
    .edge_idx_o (edge_idx),
    .sclk_o     (sclk_raw)
  );

  spi_shift_unit #(.DATA_W(DATA_W), .EDGE_W(EDGE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .tx_byte_i  (tx_byte_i),
    .tx_ph_i    (cfg_eff.tx_ph),
    .rx_ph_i    (cfg_eff.rx_ph),
    .tick_i     (tick),
    .edge_idx_i (edge_idx),
    .last_i     (last),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rx_byte_o  (rx_byte_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sclk_o = busy_q ? sclk_raw : cpol_i;

  assert_clk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (sclk_raw == cfg_q.cpol));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_ends_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !tick) |=> $stable(edge_idx) && $stable(cfg_q));
endmodule

// File: tb/spi_split_master_test.sv
module spi_split_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       cpol = 1'b0, txph = 1'b0, rxph = 1'b0;
  logic [7:0] div = '0;
  logic       miso = 1'b0;
  logic [7:0] rx_byte;
  logic       busy, done, sclk, mosi;
  int         total = 0, bad = 0;

  always #5 clk = ~clk;

  spi_split_master uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_byte_i(tx_byte),
    .cpol_i(cpol), .tx_phase_i(txph), .rx_phase_i(rxph), .div_i(div),
    .rx_byte_o(rx_byte), .busy_o(busy), .done_o(done), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int next_idx(input int e, input bit ph);
    int n;
    if (!ph) n = (e % 2 == 1) ? e + 2 : e + 1;
    else     n = (e % 2 == 0) ? e + 2 : e + 1;
    return ph ? n / 2 - 1 : (n - 1) / 2;
  endfunction

  // one transfer with full checking; disturb = inject a start mid-transfer
  task automatic do_xfer(input bit pol, input bit tp, input bit rp, input int d,
                         input logic [7:0] tx, input logic [7:0] sb, input bit disturb);
    int e = 0, cyc = 0, prev_edge = 0, done_cyc = -1;
    bit gap_ok = 1, mosi_ok = 1;
    logic last_sclk, prev_mosi;
    string rreq, treq;
    rreq = rp ? "R6" : "R5";
    treq = tp ? "R4" : "R3";
    @(negedge clk);
    prev_mosi = mosi;
    cpol = pol; txph = tp; rxph = rp; div = 8'(d); tx_byte = tx; start = 1'b1;
    miso = sb[7];
    #1;
    check(sclk == pol, "R2 idle level", sclk, pol);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    if (!tp) check(mosi == tx[7], "R3 msb before first edge", mosi, tx[7]);
    else     check(mosi == prev_mosi, "R4 output held before first edge", mosi, prev_mosi);
    last_sclk = sclk;
    while (done_cyc < 0 && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 2) begin
        start = 1'b1; tx_byte = ~tx; txph = ~tp; rxph = ~rp; div = 8'(d + 2);
      end else if (disturb && cyc == 3) begin
        start = 1'b0;
      end
      if (sclk != last_sclk) begin
        e++;
        if (cyc - prev_edge != d + 1) gap_ok = 0;
        prev_edge = cyc;
        last_sclk = sclk;
        if (!tp && (e % 2 == 1) && mosi != tx[7 - (e - 1) / 2]) mosi_ok = 0;
        if (tp && (e % 2 == 0) && mosi != tx[7 - (e / 2 - 1)]) mosi_ok = 0;
        if (next_idx(e, rp) <= 7) miso = sb[7 - next_idx(e, rp)];
      end
      if (done) done_cyc = cyc;
    end
    check(e == 16, "R8 edge count", e, 16);
    check(gap_ok, "R8 half-period", gap_ok, 1);
    check(mosi_ok, {treq, " mosi bits on slave capture edges"}, mosi_ok, 1);
    check(done_cyc == 16 * (d + 1), "R9 done timing", done_cyc, 16 * (d + 1));
    check(busy == 1'b0, "R9 busy falls with done", busy, 0);
    check(rx_byte == sb, {rreq, " received byte"}, rx_byte, sb);
    check(sclk == pol, "R2 clock back at idle", sclk, pol);
    if (disturb) check(rx_byte == sb && mosi_ok && gap_ok, "R10 start while busy ignored", rx_byte, sb);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", done, 0);
  endtask

  task automatic t_reset;
    check(busy == 0 && done == 0, "R1 flags in reset", {busy, done}, 0);
    check(mosi == 0 && rx_byte == 0, "R1 data in reset", {mosi, rx_byte}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && done == 0 && rx_byte == 0, "R1 after release", {busy, done, rx_byte}, 0);
    check(sclk == cpol, "R2 idle low", sclk, cpol);
  endtask

  task automatic t_modes;
    do_xfer(0, 0, 0, 1, 8'hA5, 8'h3C, 0);
    do_xfer(0, 1, 0, 1, 8'h5A, 8'hC3, 0);
    do_xfer(0, 0, 1, 0, 8'h81, 8'h7E, 0);
    do_xfer(0, 1, 1, 3, 8'h96, 8'h69, 0);
  endtask

  task automatic t_cpol_high;
    @(negedge clk); cpol = 1'b1; #1;
    check(sclk == 1'b1, "R2 idle high", sclk, 1);
    do_xfer(1, 0, 0, 0, 8'hF0, 8'h0F, 0);
    do_xfer(1, 1, 0, 3, 8'h33, 8'hCC, 0);
    do_xfer(1, 0, 1, 1, 8'h01, 8'h80, 0);
    do_xfer(1, 1, 1, 0, 8'hE7, 8'h18, 0);
  endtask

  task automatic t_div_max;
    do_xfer(0, 1, 0, 255, 8'h4B, 8'hB4, 0);
  endtask

  task automatic t_start_busy;
    do_xfer(0, 0, 1, 3, 8'hC9, 8'h5D, 1);
  endtask

  task automatic t_hold;
    logic [7:0] keep;
    keep = rx_byte;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      miso = ~miso;
    end
    check(rx_byte == keep, "R11 received byte held", rx_byte, keep);
    check(done == 1'b0 && busy == 1'b0, "R11 no spurious completion", {busy, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_modes();
    t_cpol_high();
    t_div_max();
    t_start_busy();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule